// File: doc/BRIEF.md
# Serial Channel Control Register with Latched Outputs

This block holds the on/off state of a set of low-side switch channels and loads it over a three-wire serial link: data, a serial clock and a latch strobe. Each serial clock rising edge moves one bit into a holding shift register. The bit pushed out of the far end goes to a serial output, so several of these blocks can be chained on one link. A rising edge on the latch strobe copies the whole holding register into an output stage. The output stage drives the channel outputs.

The serial clock, serial data and latch strobe come from outside and are not related to the system clock. They pass through short synchronizer pipelines, and edges are found in the system clock domain. The system clock must run at least four times faster than the fastest serial clock.

An active-low enable forces every channel off, but shifting and latching keep running underneath it. A per-channel fault input and a global shutdown input also force channels off. An active-high clear input empties the holding register, the output stage and the serial output together. A power-on reset does the same without any pulse on the clear input.

Top module: `serial_chan_latch`

## Requirements
- R1: Each rising edge of `sclk` shifts the holding register by one place, with `sdin` entering at the channel-1 end. After four edges, the first bit sent controls channel 4 (`ch_on[3]`) and the last bit sent controls channel 1 (`ch_on[0]`).
- R2: On each `sclk` rising edge, `sdout` takes the bit that leaves the channel-4 stage of the holding register. This is the value that stage held before the edge, so `sdout` repeats the input stream delayed by four shifts, for cascading.
- R3: A rising edge of `latch` copies the whole holding register into the output stage. The output stage does not change at any other time, whatever happens on the serial input.
- R4: While `clr` is high, the holding register, the output stage and `sdout` are cleared. After a clear, a latch edge with no new shifts gives all channels off.
- R5: While `en_n` is high, every `ch_on` bit is 0. Shifting, `sdout` and latching keep working. Once `en_n` goes low, the outputs show the data latched while the block was disabled.
- R6: A 1 in an output-stage bit turns its channel on. `fault[i]` high forces channel i off, and `shutdown` high forces every channel off.
- R7: While `por_n` is low, all registers clear, with no pulse needed on `clr`.
- R8: `sclk`, `sdin` and `latch` are sampled through a `SYNC_STAGES`-deep synchronizer. Each level of `sclk` and `latch` must last at least two system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| sclk | input | 1 | Serial clock; data shifts on its rising edge |
| sdin | input | 1 | Serial data in |
| latch | input | 1 | Rising edge moves the holding register into the output stage |
| clr | input | 1 | Synchronous clear of all serial registers, active high |
| en_n | input | 1 | Output enable, active low |
| fault | input | NCH | Per-channel protection fault, forces that channel off |
| shutdown | input | 1 | Global shutdown, forces all channels off |
| sdout | output | 1 | Serial data out, for cascading |
| ch_on | output | NCH | Channel switch-on outputs |

## Verification
The assertions assume that `sclk` and `latch` hold each level long enough to be seen by the synchronizer. Under that assumption every detected edge matches exactly one pin edge, and the stage-stability and shift-out properties can be stated against the internal edge pulses. The bench holds every `sclk` and `latch` level for several system clocks and changes `sdin` only while `sclk` is low and settled. Random data, enable, fault and shutdown patterns are mixed with directed cases for bit order, clear, and latching with no new shifts.

// File: rtl/serial_chan_latch.sv
module serial_chan_latch #(
  parameter int NCH         = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           por_n,
  input  logic           sclk,
  input  logic           sdin,
  input  logic           latch,
  input  logic           clr,
  input  logic           en_n,
  input  logic [NCH-1:0] fault,
  input  logic           shutdown,
  output logic           sdout,
  output logic [NCH-1:0] ch_on
);
  localparam int PIPE = SYNC_STAGES + 1;

  logic [PIPE-1:0] sclk_p, latch_p, din_p;
  logic [NCH-1:0]  hold, stage;
  logic            sclk_rise, latch_rise, din_s;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      sclk_p  <= '0;
      latch_p <= '0;
      din_p   <= '0;
    end else begin
      sclk_p  <= {sclk_p[PIPE-2:0], sclk};
      latch_p <= {latch_p[PIPE-2:0], latch};
      din_p   <= {din_p[PIPE-2:0], sdin};
    end

  assign sclk_rise  = sclk_p[PIPE-2] & ~sclk_p[PIPE-1];
  assign latch_rise = latch_p[PIPE-2] & ~latch_p[PIPE-1];
  assign din_s      = din_p[PIPE-2];

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      hold  <= '0;
      stage <= '0;
      sdout <= 1'b0;
    end else if (clr) begin
      hold  <= '0;
      stage <= '0;
      sdout <= 1'b0;
    end else begin
      if (sclk_rise) begin
        hold  <= {hold[NCH-2:0], din_s};
        sdout <= hold[NCH-1];
      end
      if (latch_rise) stage <= hold;
    end

  assign ch_on = stage & ~fault & {NCH{~(en_n | shutdown)}};
endmodule

module serial_chan_latch_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           por_n,
  input logic           clr,
  input logic           en_n,
  input logic           shutdown,
  input logic [NCH-1:0] fault,
  input logic           sclk_rise,
  input logic           latch_rise,
  input logic [NCH-1:0] hold,
  input logic [NCH-1:0] stage,
  input logic           sdout,
  input logic [NCH-1:0] ch_on
);
  // R2
  shift_out_chk: assert property (@(posedge clk) disable iff (!por_n)
    (sclk_rise && !clr) |=> (sdout == $past(hold[NCH-1])));
  // R3
  stage_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!latch_rise && !clr) |=> $stable(stage));
  // R3
  stage_load_chk: assert property (@(posedge clk) disable iff (!por_n)
    (latch_rise && !clr) |=> (stage == $past(hold)));
  // R4
  clear_all_chk: assert property (@(posedge clk) disable iff (!por_n)
    clr |=> (hold == '0 && stage == '0 && !sdout));
  // R5
  disable_off_chk: assert property (@(posedge clk) disable iff (!por_n)
    en_n |-> (ch_on == '0));
  // R6
  fault_off_chk: assert property (@(posedge clk) disable iff (!por_n)
    ((ch_on & (fault | {NCH{shutdown}})) == '0) && ((ch_on & ~stage) == '0));
endmodule

bind serial_chan_latch serial_chan_latch_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .por_n(por_n), .clr(clr), .en_n(en_n), .shutdown(shutdown),
  .fault(fault), .sclk_rise(sclk_rise), .latch_rise(latch_rise),
  .hold(hold), .stage(stage), .sdout(sdout), .ch_on(ch_on));

// File: tb/serial_chan_latch_tb.sv
module serial_chan_latch_tb;
  localparam int CLK_P = 10;
  localparam int N = 4;

  logic clk = 0, por_n = 0, sclk = 0, sdin = 0, latch = 0, clr = 0, en_n = 0, shutdown = 0;
  logic [N-1:0] fault = '0;
  logic sdout;
  logic [N-1:0] ch_on;
  logic [N-1:0] m_hold = '0, m_stage = '0;
  logic m_sdo = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  serial_chan_latch #(.NCH(N), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .por_n(por_n), .sclk(sclk), .sdin(sdin), .latch(latch), .clr(clr),
    .en_n(en_n), .fault(fault), .shutdown(shutdown), .sdout(sdout), .ch_on(ch_on));

  function automatic logic [N-1:0] exp_on(logic [N-1:0] st, logic en, logic [N-1:0] f, logic sd);
    return (en || sd) ? '0 : (st & ~f);
  endfunction

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic send_bit(logic b);
    sdin = b;
    wait_clk(3);
    sclk = 1;
    wait_clk(4);
    sclk = 0;
    wait_clk(3);
    m_sdo  = m_hold[N-1];
    m_hold = {m_hold[N-2:0], b};
  endtask

  task automatic do_latch();
    latch = 1;
    wait_clk(4);
    latch = 0;
    wait_clk(3);
    m_stage = m_hold;
  endtask

  task automatic do_clear();
    clr = 1;
    wait_clk(2);
    clr = 0;
    wait_clk(1);
    m_hold = '0; m_stage = '0; m_sdo = 0;
  endtask

  initial begin
    void'($urandom(32'h5eed));
    wait_clk(3);
    // R7 reset state
    chk("R7", ch_on, '0);
    chk("R7", {3'b0, sdout}, '0);
    por_n = 1;
    wait_clk(2);

    // R1 first bit controls channel 4
    send_bit(1); send_bit(0); send_bit(0); send_bit(0);
    do_latch();
    chk("R1", ch_on, 4'b1000);
    send_bit(0); send_bit(0); send_bit(0); send_bit(1);
    do_latch();
    chk("R1", ch_on, 4'b0001);

    // R3 shifting alone leaves outputs unchanged
    send_bit(1); send_bit(1);
    chk("R3", ch_on, 4'b0001);

    // R4 clear, then latch with no shifts
    do_clear();
    chk("R4", ch_on, '0);
    chk("R4", {3'b0, sdout}, '0);
    do_latch();
    chk("R4", ch_on, '0);

    // R2 / R8 random stream with cascade output checked per bit
    for (int i = 0; i < 40; i++) begin
      send_bit(1'($urandom));
      chk("R2", {3'b0, sdout}, {3'b0, m_sdo});
      if ($urandom % 5 == 0) begin
        do_latch();
        chk("R8", ch_on, exp_on(m_stage, en_n, fault, shutdown));
      end
    end

    // R5 disabled: shift and latch still work
    en_n = 1;
    for (int i = 0; i < N; i++) send_bit(1'($urandom));
    do_latch();
    chk("R5", ch_on, '0);
    en_n = 0;
    wait_clk(1);
    chk("R5", ch_on, m_stage);

    // R6 random fault and shutdown patterns
    for (int i = 0; i < 30; i++) begin
      for (int k = 0; k < N; k++) send_bit(1'($urandom));
      do_latch();
      fault = N'($urandom);
      shutdown = ($urandom % 4 == 0);
      en_n = ($urandom % 4 == 0);
      wait_clk(1);
      chk("R6", ch_on, exp_on(m_stage, en_n, fault, shutdown));
    end
    fault = '0; shutdown = 0; en_n = 0;

    // R7 power-on reset mid-operation
    for (int k = 0; k < N; k++) send_bit(1);
    do_latch();
    por_n = 0;
    wait_clk(2);
    chk("R7", ch_on, '0);
    por_n = 1;
    m_hold = '0; m_stage = '0;
    wait_clk(2);
    do_latch();
    chk("R7", ch_on, '0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule